// File: doc/BRIEF.md
# Windowed Mailbox Message Queue Engine

This block is a set of hardware message queues that processors use to pass fixed-size messages to one another through plain 32-bit register accesses. Each queue has a sixteen-word data window. A producer fills the window one word at a time. Its access to the final word of the window commits the whole message into the queue. A consumer reads the same window layout. It receives the words of the oldest message, and its read of the final word removes that message.

Each queue also has a status word in a separate region. The status word reports how many messages the queue holds and whether a commit was ever lost because the queue was full. Each queue drives a level interrupt that stays high while the queue holds any message. The write and read sides have their own address and enable, so one producer access and one consumer access can both happen in the same cycle. Read data is registered and returned one cycle after the request.

Top module: `msgq_engine`

## Requirements
- R1: A data register sits at byte address queue*0x80 + reg*4, with address bit 23 clear and the bits 22:16 all zero. Only registers 16 to 31 are data. Any other data-region address is ignored: writes to it do nothing, reads from it return 0, and a read there never pops. This covers a nonzero field in bits 22:16, a register number below 16, and a queue number of 4 or more.
- R2: Writes to registers 16 to 30 of a queue are held in that queue's staging words. A write to register 31 commits the sixteen words into the queue, with the register 31 word last. The commit then clears the staging words, so any word not written before the next commit reads back as 0.
- R3: A read of registers 16 to 31 returns word (reg-16) of the queue's oldest message. rd_data and rd_valid appear on the clock edge that follows the request. Reads of registers 16 to 30 leave the queue unchanged.
- R4: A read of register 31 returns the last word of the oldest message and then removes that message. The count drops by one, and the next read sees the following message.
- R5: The status word of queue q is at byte address 0x800000 + q*4 (address bit 23 set). Its bits 23:12 hold the message count, bit 0 is the overflow flag, and all other bits read 0.
- R6: A commit to a queue that holds 4 messages is dropped. The stored messages stay unchanged and the queue's overflow flag sets. Only reset clears the flag.
- R7: A register 31 read from an empty queue returns 0 and leaves the count at 0.
- R8: irq[q] is high exactly while queue q holds at least one message. It changes on the same edge as the count.
- R9: A commit and a register 31 read on the same queue in the same cycle work as follows. If the queue is not empty, the count stays the same, including when the queue is full, and no overflow is flagged. If the queue is empty, the read returns 0 and the count becomes 1.
- R10: After reset, all counts are 0, all staging words are 0, all overflow flags are clear, all interrupts are low, and rd_valid is low.
- R11: Each queue keeps up to 4 messages in first-in first-out order, independently of the other queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 24 | Byte address of the write |
| wr_data | input | 32 | Write data word |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 24 | Byte address of the read |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High on the cycle after a read request |
| irq | output | 4 | Per-queue level interrupt |

## Verification
A commit (a write to register 31) and a pop (a read of register 31) can land on the same queue in the same cycle. This is the case most likely to corrupt the count or the storage. Directed steps provoke it on an empty queue, a partly filled queue and a full queue. The random phase also pairs write and read accesses at random. The reference model in the bench applies the pop before it judges whether the commit fits. It then compares the returned word, which must come from the state before the cycle, and the interrupt level. A later status read and a later drain of the queue confirm that the count and the message order came out right.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam int WIN_WORDS   = 16;  // data words per message window
  localparam int FIRST_DATA  = 16;  // first data register number
  localparam int CNT_FIELD_W = 12;  // width of the count field in the status word
  localparam int CNT_LSB     = 12;  // position of the count field

  function automatic logic [31:0] status_word(input logic [CNT_FIELD_W-1:0] cnt,
                                              input logic ovf);
    logic [31:0] w;
    w = '0;
    w[CNT_LSB +: CNT_FIELD_W] = cnt;
    w[0] = ovf;
    return w;
  endfunction
endpackage

// File: rtl/msgq_addr_dec.sv
module msgq_addr_dec #(
  parameter int ADDR_W = 24,
  parameter int NUM_Q  = 4,
  localparam int QW    = $clog2(NUM_Q)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              data_hit,
  output logic              state_hit,
  output logic [QW-1:0]     qid,
  output logic [3:0]        widx
);
  localparam logic [8:0]        QLIM = 9'(NUM_Q);
  localparam logic [ADDR_W-3:0] SLIM = (ADDR_W-2)'(NUM_Q);

  logic              aligned;
  logic [8:0]        q_field;
  logic [ADDR_W-3:0] s_field;

  always_comb begin
    aligned   = (addr[1:0] == 2'b00);
    q_field   = addr[15:7];
    s_field   = addr[ADDR_W-2:2];
    data_hit  = 1'b0;
    state_hit = 1'b0;
    qid       = '0;
    widx      = addr[5:2];
    if (!addr[ADDR_W-1]) begin
      data_hit = aligned && (addr[ADDR_W-2:16] == '0) && addr[6] && (q_field < QLIM);
      qid      = addr[7 +: QW];
    end else begin
      state_hit = aligned && (s_field < SLIM);
      qid       = addr[2 +: QW];
    end
  end
endmodule

// File: rtl/msgq_queue.sv
module msgq_queue #(
  parameter int DEPTH = 4,
  parameter int WORDS = 16,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stage_we,
  input  logic [IW-1:0] stage_idx,
  input  logic [DW-1:0] stage_data,
  input  logic          pop,
  input  logic [IW-1:0] peek_idx,
  output logic [DW-1:0] peek_word,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          irq
);
  logic [DW-1:0] stg [WORDS];
  logic [DW-1:0] mem [DEPTH][WORDS];
  logic [PW-1:0] head, tail;
  logic          commit, full, empty, do_pop, do_push;
  logic [CW-1:0] cnt_nxt;

  assign commit  = stage_we && (stage_idx == IW'(WORDS - 1));
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = commit && (!full || do_pop);

  always_comb begin
    cnt_nxt = count;
    if (do_push && !do_pop)      cnt_nxt = count + 1'b1;
    else if (do_pop && !do_push) cnt_nxt = count - 1'b1;
  end

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      ovf   <= 1'b0;
      irq   <= 1'b0;
      for (int w = 0; w < WORDS; w++) stg[w] <= '0;
    end else begin
      count <= cnt_nxt;
      irq   <= (cnt_nxt != '0);
      if (do_pop)  head <= wrap_inc(head);
      if (do_push) tail <= wrap_inc(tail);
      if (commit && !do_push) ovf <= 1'b1;
      if (commit) begin
        for (int w = 0; w < WORDS; w++) stg[w] <= '0;
      end else if (stage_we) begin
        stg[stage_idx] <= stage_data;
      end
    end
  end

  // message storage: no reset, one whole line written per commit
  always_ff @(posedge clk) begin
    if (do_push) begin
      for (int w = 0; w < WORDS; w++)
        mem[tail][w] <= (w == WORDS - 1) ? stage_data : stg[w];
    end
  end

  assign peek_word = empty ? '0 : mem[head][peek_idx];

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));                                           // R11
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == (count != '0));                                          // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);                                                   // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    commit && full && !pop |=> $stable(count) && ovf);              // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    pop && empty && !commit |=> count == '0);                       // R7
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    commit && pop && !empty |=> $stable(count));                    // R9
endmodule

// File: rtl/msgq_engine.sv
module msgq_engine #(
  parameter int ADDR_W = 24,
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 4,
  localparam int DW    = 32,
  localparam int QW    = $clog2(NUM_Q),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic [NUM_Q-1:0]  irq
);
  import msgq_pkg::*;

  logic          w_data_hit, w_state_hit, r_data_hit, r_state_hit;
  logic [QW-1:0] w_qid, r_qid;
  logic [3:0]    w_widx, r_widx;
  logic [DW-1:0] q_word [NUM_Q];
  logic [DW-1:0] q_stat [NUM_Q];
  logic [DW-1:0] rd_nxt;

  msgq_addr_dec #(.ADDR_W(ADDR_W), .NUM_Q(NUM_Q)) i_wdec (
    .addr(wr_addr), .data_hit(w_data_hit), .state_hit(w_state_hit),
    .qid(w_qid), .widx(w_widx));

  msgq_addr_dec #(.ADDR_W(ADDR_W), .NUM_Q(NUM_Q)) i_rdec (
    .addr(rd_addr), .data_hit(r_data_hit), .state_hit(r_state_hit),
    .qid(r_qid), .widx(r_widx));

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic [CW-1:0] cnt;
    logic          ovf;
    msgq_queue #(.DEPTH(DEPTH), .WORDS(WIN_WORDS), .DW(DW)) i_queue (
      .clk       (clk),
      .rst       (rst),
      .stage_we  (wr_en && w_data_hit && (w_qid == QW'(q))),
      .stage_idx (w_widx),
      .stage_data(wr_data),
      .pop       (rd_en && r_data_hit && (r_qid == QW'(q)) && (r_widx == 4'hF)),
      .peek_idx  (r_widx),
      .peek_word (q_word[q]),
      .count     (cnt),
      .ovf       (ovf),
      .irq       (irq[q])
    );
    assign q_stat[q] = status_word(CNT_FIELD_W'(cnt), ovf);
  end

  always_comb begin
    rd_nxt = '0;
    if (r_data_hit)       rd_nxt = q_word[r_qid];
    else if (r_state_hit) rd_nxt = q_stat[r_qid];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_nxt;
    end
  end

  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);                                            // R3
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);                                          // R3
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en && !r_data_hit && !r_state_hit |=> rd_data == '0);        // R1
endmodule

// File: tb/test_msgq_engine.sv
module test_msgq_engine;
  localparam int NQ = 4;
  localparam int DEP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [23:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [NQ-1:0] irq;

  always #5 clk = ~clk;

  msgq_engine i_msgq_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq(irq));

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // reference model
  logic [31:0] m_mem [NQ][DEP][16];
  logic [31:0] m_stg [NQ][16];
  int          m_head [NQ];
  int          m_cnt  [NQ];
  bit          m_ovf  [NQ];

  function automatic logic [23:0] daddr(int q, int r);
    return 24'(q * 32'h80 + r * 4);
  endfunction
  function automatic logic [23:0] saddr(int q);
    return 24'h800000 | 24'(q * 4);
  endfunction
  function automatic logic [31:0] exp_status(int q);
    logic [31:0] w;
    w = '0;
    w[23:12] = 12'(m_cnt[q]);
    w[0] = m_ovf[q];
    return w;
  endfunction
  function automatic logic [31:0] exp_word(int q, int r);
    if (m_cnt[q] == 0) return '0;
    return m_mem[q][m_head[q]][r-16];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int q = 0; q < NQ; q++) begin
      m_head[q] = 0; m_cnt[q] = 0; m_ovf[q] = 1'b0;
      for (int w = 0; w < 16; w++) m_stg[q][w] = '0;
    end
  endtask

  // wk: 0 none, 1 data, 2 bad; rk: 0 none, 1 data, 2 status, 3 bad
  task automatic step(int wk, int wq, int wr, logic [31:0] wd,
                      int rk, int rq, int rr, string tag);
    logic [31:0] exp_r;
    bit pop_ok, accept;
    int cnt_pre, t;
    logic [31:0] line [16];
    wr_en   = (wk != 0);
    wr_data = wd;
    wr_addr = (wk == 2) ? (daddr(wq, wr) | 24'h010000) : daddr(wq, wr);
    rd_en   = (rk != 0);
    case (rk)
      1: rd_addr = daddr(rq, rr);
      2: rd_addr = saddr(rq);
      3: rd_addr = (rr < 16) ? daddr(rq, rr) : (daddr(rq, rr) | 24'h020000);
      default: rd_addr = '0;
    endcase
    exp_r = '0;
    if (rk == 1) exp_r = exp_word(rq, rr);
    if (rk == 2) exp_r = exp_status(rq);
    // model update: pop first, then judge the commit
    pop_ok = (rk == 1) && (rr == 31) && (m_cnt[rq] > 0);
    cnt_pre = (wk == 1) ? m_cnt[wq] : 0;
    if (pop_ok) begin
      m_head[rq] = (m_head[rq] + 1) % DEP;
      m_cnt[rq]--;
    end
    if (wk == 1) begin
      if (wr == 31) begin
        for (int w = 0; w < 15; w++) line[w] = m_stg[wq][w];
        line[15] = wd;
        for (int w = 0; w < 16; w++) m_stg[wq][w] = '0;
        accept = (cnt_pre < DEP) || (pop_ok && rq == wq);
        if (accept) begin
          t = (m_head[wq] + m_cnt[wq]) % DEP;
          for (int w = 0; w < 16; w++) m_mem[wq][t][w] = line[w];
          m_cnt[wq]++;
        end else m_ovf[wq] = 1'b1;
      end else if (wr >= 16) begin
        m_stg[wq][wr-16] = wd;
      end
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    if (rk != 0) begin
      check({tag, " rd_valid R3"}, 32'(rd_valid), 32'd1);
      check({tag, " rd_data"}, rd_data, exp_r);
    end
    for (int q = 0; q < NQ; q++)
      check({tag, " irq R8"}, 32'(irq[q]), 32'(m_cnt[q] != 0));
  endtask

  task automatic push_msg(int q, logic [31:0] base, string tag);
    for (int r = 16; r < 32; r++) step(1, q, r, base + 32'(r), 0, 0, 0, tag);
  endtask
  task automatic pop_msg(int q, string tag);
    for (int r = 16; r < 32; r++) step(0, 0, 0, '0, 1, q, r, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 rd_valid", 32'(rd_valid), 32'd0);
    check("R10 irq", 32'(irq), 32'd0);
    for (int q = 0; q < NQ; q++) step(0, 0, 0, '0, 2, q, 0, "R10 status");

    // R2/R4/R11: fill queue 0, read back in order
    for (int m = 0; m < DEP; m++) push_msg(0, 32'h1000 * 32'(m + 1), "R11 fill");
    step(0, 0, 0, '0, 2, 0, 0, "R5 status full");
    // R6: fifth commit dropped
    push_msg(0, 32'hDEAD0000, "R6 overflow");
    step(0, 0, 0, '0, 2, 0, 0, "R6 status ovf");
    step(0, 0, 0, '0, 1, 0, 20, "R3 peek");
    step(0, 0, 0, '0, 1, 0, 20, "R3 peek unchanged");
    for (int m = 0; m < DEP; m++) pop_msg(0, "R4 drain");
    // R7: pop empty
    step(0, 0, 0, '0, 1, 0, 31, "R7 empty pop");
    step(0, 0, 0, '0, 2, 0, 0, "R7 status");
    // R2: partial message, unwritten words zero
    step(1, 1, 18, 32'hAAAA5555, 0, 0, 0, "R2 partial");
    step(1, 1, 31, 32'h0, 0, 0, 0, "R2 commit");
    pop_msg(1, "R2 readback");
    // R1: bad addresses
    step(2, 2, 31, 32'h12345678, 0, 0, 0, "R1 bad write");
    step(0, 0, 0, '0, 2, 2, 0, "R1 status after bad write");
    push_msg(2, 32'h2200, "R1 setup");
    step(0, 0, 0, '0, 3, 2, 31, "R1 bad read proxy");
    step(0, 0, 0, '0, 3, 2, 5, "R1 bad read low reg");
    step(0, 0, 0, '0, 2, 2, 0, "R1 count kept");
    // R9: simultaneous commit and pop
    step(1, 3, 31, 32'h33, 1, 3, 31, "R9 empty both");
    step(0, 0, 0, '0, 2, 3, 0, "R9 status empty case");
    step(1, 2, 31, 32'h44, 1, 2, 31, "R9 partial both");
    for (int m = 0; m < 3; m++) push_msg(3, 32'h3300 + 32'(m), "R9 fill");
    step(1, 3, 31, 32'h55, 1, 3, 31, "R9 full both");
    step(0, 0, 0, '0, 2, 3, 0, "R9 status full case");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int wk, rk, wq, rq, wr, rr, sel;
      sel = int'($urandom_range(0, 99));
      wk = (sel < 55) ? 1 : ((sel < 60) ? 2 : 0);
      wq = int'($urandom_range(0, NQ - 1));
      wr = ($urandom_range(0, 3) == 0) ? 31 : int'($urandom_range(16, 31));
      sel = int'($urandom_range(0, 99));
      rk = (sel < 50) ? 1 : ((sel < 65) ? 2 : ((sel < 70) ? 3 : 0));
      rq = int'($urandom_range(0, NQ - 1));
      rr = ($urandom_range(0, 3) == 0) ? 31 : int'($urandom_range(16, 31));
      if (rk == 3 && $urandom_range(0, 1) == 0) rr = int'($urandom_range(0, 15));
      step(wk, wq, wr, $urandom(), rk, rq, rr, "R3 R4 R11 random");
    end
    for (int q = 0; q < NQ; q++) step(0, 0, 0, '0, 2, q, 0, "R5 final status");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule